// File: doc/BRIEF.md
# Performance Counter Access Decoder

This block sits in front of a bank of general-purpose and fixed-function event counters and turns register-style accesses into writes and reads on an external counter array. Every general-purpose counter can be written through two aliases. The legacy alias accepts only a 32-bit value and sign-extends it. The full-width alias accepts a value up to the counter width and refuses anything wider. Fixed counters have a single write path that truncates the value to their width. The counter array is outside this block. It holds one storage word per counter, so both aliases read back the same contents.

Reads use a 32-bit index word. Bit 30 picks the fixed class, bits 29:0 give the counter number within that class, and bit 31 asks for a fast 32-bit result. The block drives the select lines of the array, forms the result, and returns it one cycle later with a valid strobe. A counter number beyond the implemented count produces a fault pulse on that channel, on writes and on reads alike.

Top module: `ctr_access_front`

## Requirements
- R1: A write with `wr_kind` = 0 (legacy alias) to general-purpose counter n stores bits 31:0 of `wr_data`, sign-extended from bit 31 and cut to GP_W bits.
- R2: A write with `wr_kind` = 1 (full-width alias) whose data has no bit set at or above bit GP_W stores the data unchanged.
- R3: A full-width alias write with any data bit set at or above bit GP_W leaves the counter unchanged, and `wr_fault` is high in the following cycle.
- R4: A write with `wr_kind` = 2 (fixed class) to fixed counter n stores the low FX_W bits of `wr_data`.
- R5: A write whose counter number is not below the count of its class (NUM_GP or NUM_FX) changes no counter, and `wr_fault` is high in the following cycle.
- R6: In `rd_index`, bit 30 = 1 selects the fixed class and bits 29:0 give the counter number. A general-purpose counter reads back the same value whichever alias last wrote it.
- R7: When bit 31 of `rd_index` is set, `rd_data` holds only the low 32 bits of the counter, with bits 63:32 zero. When bit 31 is clear, the counter is returned zero-extended to 64 bits.
- R8: A read whose counter number is not below the count of its class gives `rd_valid` = 1, `rd_data` = 0 and `rd_fault` = 1 in the following cycle.
- R9: After a synchronous reset, all outputs are zero. `rd_valid` is high exactly in the cycle after `rd_en`. `rd_data` is zero whenever `rd_valid` is low. A read in the same cycle as a write to the same counter returns the value held before that write.
- R10: A write with `wr_kind` = 3, or with `wr_en` low, changes no counter and raises no fault. At most one of `gp_we` and `fx_we` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request this cycle |
| wr_kind | input | 2 | 0 legacy alias, 1 full-width alias, 2 fixed counter, 3 no operation |
| wr_num | input | NUM_W | Counter number within the class being written |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read request this cycle |
| rd_index | input | 32 | Read index: bit 31 fast mode, bit 30 fixed class, bits 29:0 counter number |
| gp_we | output | 1 | Write strobe to the general-purpose array |
| gp_wsel | output | GP_SEL_W | General-purpose write address |
| gp_wval | output | GP_W | General-purpose write value |
| fx_we | output | 1 | Write strobe to the fixed array |
| fx_wsel | output | FX_SEL_W | Fixed write address |
| fx_wval | output | FX_W | Fixed write value |
| gp_rsel | output | GP_SEL_W | General-purpose read address |
| gp_rval | input | GP_W | General-purpose read data, combinational from the array |
| fx_rsel | output | FX_SEL_W | Fixed read address |
| fx_rval | input | FX_W | Fixed read data, combinational from the array |
| wr_fault | output | 1 | Write rejected, one cycle after the write |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 64 | Read result |
| rd_fault | output | 1 | Read index out of range, alongside rd_valid |

## Verification
The bench targets the sign boundary of the legacy alias. It writes data with bit 31 set, and data with bit 31 clear but junk in the upper half. A design that zero-extends, or that passes the upper word through, reads back the wrong upper bits. Full-width writes are tested at the width edge: all ones below bit GP_W must be stored, and a single bit at GP_W must fault. A design that compares against the wrong bit either corrupts the counter or rejects a legal value. Reads cover both class bits, fast mode, and indices that are one past the count or that have high number bits set. A decoder that looks only at the select bits would alias such an index onto a real counter instead of faulting. One cycle reads and writes the same counter, so a read that forwards the new value shows up.

// File: rtl/ctr_access_pkg.sv
// Shared types and helpers for the counter access decoder.
// Assumes counter widths between 33 and 64 bits.
package ctr_access_pkg;

    typedef enum logic [1:0] {
        WK_LEGACY = 2'd0,
        WK_FULL   = 2'd1,
        WK_FIXED  = 2'd2,
        WK_NONE   = 2'd3
    } wr_kind_e;

    // Mask with the low w bits set.
    function automatic logic [63:0] low_ones(input int w);
        if (w >= 64) return '1;
        return (64'd1 << w) - 64'd1;
    endfunction

endpackage

// File: rtl/ctr_wr_decode.sv
// Write decoder: maps an alias write onto one of the two counter arrays.
// Applies the sign-extension and width rules of each alias and flags
// rejected writes one cycle later. Assumes GP_W > 32 and NUM_W >= select widths.
module ctr_wr_decode
    import ctr_access_pkg::*;
#(
    parameter int NUM_GP   = 4,
    parameter int NUM_FX   = 3,
    parameter int GP_W     = 48,
    parameter int FX_W     = 40,
    parameter int NUM_W    = 4,
    parameter int GP_SEL_W = 2,
    parameter int FX_SEL_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_kind,
    input  logic [NUM_W-1:0]    wr_num,
    input  logic [63:0]         wr_data,
    output logic                gp_we,
    output logic [GP_SEL_W-1:0] gp_wsel,
    output logic [GP_W-1:0]     gp_wval,
    output logic                fx_we,
    output logic [FX_SEL_W-1:0] fx_wsel,
    output logic [FX_W-1:0]     fx_wval,
    output logic                wr_fault
);

    localparam logic [63:0]      GP_HI  = ~low_ones(GP_W);
    localparam logic [NUM_W-1:0] GP_LIM = NUM_W'(NUM_GP);
    localparam logic [NUM_W-1:0] FX_LIM = NUM_W'(NUM_FX);

    wr_kind_e         kind;
    logic             gp_hit;
    logic             fx_hit;
    logic             too_wide;
    logic             flt_now;
    logic [GP_W-1:0]  legacy_val;

    assign kind       = wr_kind_e'(wr_kind);
    assign gp_hit     = wr_num < GP_LIM;
    assign fx_hit     = wr_num < FX_LIM;
    assign too_wide   = |(wr_data & GP_HI);
    assign legacy_val = {{(GP_W-32){wr_data[31]}}, wr_data[31:0]};
    assign gp_wsel    = wr_num[GP_SEL_W-1:0];
    assign fx_wsel    = wr_num[FX_SEL_W-1:0];
    assign fx_wval    = wr_data[FX_W-1:0];

    // Choose the target array, the stored value and the fault per alias.
    always_comb begin
        gp_we   = 1'b0;
        fx_we   = 1'b0;
        flt_now = 1'b0;
        gp_wval = wr_data[GP_W-1:0];
        unique case (kind)
            WK_LEGACY: begin
                gp_wval = legacy_val;
                gp_we   = wr_en & gp_hit;
                flt_now = wr_en & ~gp_hit;
            end
            WK_FULL: begin
                gp_we   = wr_en & gp_hit & ~too_wide;
                flt_now = wr_en & (~gp_hit | too_wide);
            end
            WK_FIXED: begin
                fx_we   = wr_en & fx_hit;
                flt_now = wr_en & ~fx_hit;
            end
            default: begin
                gp_we   = 1'b0;
            end
        endcase
    end

    // Register the write fault so it pulses in the cycle after the access.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_fault <= 1'b0;
        else        wr_fault <= flt_now;
    end

    // R3: an oversize full-width write never reaches the array and faults next cycle.
    p_wide_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == 2'd1 && (wr_data[63:GP_W] != '0)) |-> !gp_we);
    p_wide_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == 2'd1 && (wr_data[63:GP_W] != '0)) |=> wr_fault);
    // R10: the two array strobes are exclusive; an idle or no-op write never faults.
    p_one_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(gp_we && fx_we));
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_kind == 2'd3) |=> !wr_fault);

endmodule

// File: rtl/ctr_rd_decode.sv
// Read decoder: splits the 32-bit read index into class, number and fast
// flag, drives the array selects and registers the formatted result.
// Assumes the arrays answer combinationally within the same cycle.
module ctr_rd_decode #(
    parameter int NUM_GP   = 4,
    parameter int NUM_FX   = 3,
    parameter int GP_W     = 48,
    parameter int FX_W     = 40,
    parameter int GP_SEL_W = 2,
    parameter int FX_SEL_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [31:0]         rd_index,
    output logic [GP_SEL_W-1:0] gp_rsel,
    input  logic [GP_W-1:0]     gp_rval,
    output logic [FX_SEL_W-1:0] fx_rsel,
    input  logic [FX_W-1:0]     fx_rval,
    output logic                rd_valid,
    output logic [63:0]         rd_data,
    output logic                rd_fault
);

    localparam logic [29:0] GP_LIM = 30'(NUM_GP);
    localparam logic [29:0] FX_LIM = 30'(NUM_FX);

    logic        fast;
    logic        is_fx;
    logic [29:0] num;
    logic        hit;
    logic [63:0] raw;
    logic [63:0] shaped;

    assign fast    = rd_index[31];
    assign is_fx   = rd_index[30];
    assign num     = rd_index[29:0];
    assign gp_rsel = num[GP_SEL_W-1:0];
    assign fx_rsel = num[FX_SEL_W-1:0];

    // Range check per class, then pick and shape the returned value.
    always_comb begin
        hit = is_fx ? (num < FX_LIM) : (num < GP_LIM);
        raw = is_fx ? 64'(fx_rval) : 64'(gp_rval);
        if (!hit)      shaped = '0;
        else if (fast) shaped = {32'd0, raw[31:0]};
        else           shaped = raw;
    end

    // Register the result with its strobe; data is zero when not valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_fault <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? shaped : '0;
            rd_fault <= rd_en & ~hit;
        end
    end

    // R9: one result per request, a quiet bus otherwise.
    p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    p_quiet_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && rd_data == '0 && !rd_fault));
    // R7: a fast read never returns upper bits.
    p_fast_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_index[31]) |=> (rd_data[63:32] == 32'd0));
    // R8: a faulting read still completes, with zero data.
    p_oob_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fault |-> (rd_valid && rd_data == '0));

endmodule

// File: rtl/ctr_access_front.sv
// Counter access front end: joins the write decoder and the read decoder
// that share one external counter array. Holds no counter state itself.
module ctr_access_front #(
    parameter int NUM_GP   = 4,
    parameter int NUM_FX   = 3,
    parameter int GP_W     = 48,
    parameter int FX_W     = 40,
    parameter int NUM_W    = 4,
    localparam int GP_SEL_W = (NUM_GP > 1) ? $clog2(NUM_GP) : 1,
    localparam int FX_SEL_W = (NUM_FX > 1) ? $clog2(NUM_FX) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_kind,
    input  logic [NUM_W-1:0]    wr_num,
    input  logic [63:0]         wr_data,
    input  logic                rd_en,
    input  logic [31:0]         rd_index,
    output logic                gp_we,
    output logic [GP_SEL_W-1:0] gp_wsel,
    output logic [GP_W-1:0]     gp_wval,
    output logic                fx_we,
    output logic [FX_SEL_W-1:0] fx_wsel,
    output logic [FX_W-1:0]     fx_wval,
    output logic [GP_SEL_W-1:0] gp_rsel,
    input  logic [GP_W-1:0]     gp_rval,
    output logic [FX_SEL_W-1:0] fx_rsel,
    input  logic [FX_W-1:0]     fx_rval,
    output logic                wr_fault,
    output logic                rd_valid,
    output logic [63:0]         rd_data,
    output logic                rd_fault
);

    ctr_wr_decode #(
        .NUM_GP(NUM_GP), .NUM_FX(NUM_FX), .GP_W(GP_W), .FX_W(FX_W),
        .NUM_W(NUM_W), .GP_SEL_W(GP_SEL_W), .FX_SEL_W(FX_SEL_W)
    ) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_num(wr_num), .wr_data(wr_data),
        .gp_we(gp_we), .gp_wsel(gp_wsel), .gp_wval(gp_wval),
        .fx_we(fx_we), .fx_wsel(fx_wsel), .fx_wval(fx_wval),
        .wr_fault(wr_fault)
    );

    ctr_rd_decode #(
        .NUM_GP(NUM_GP), .NUM_FX(NUM_FX), .GP_W(GP_W), .FX_W(FX_W),
        .GP_SEL_W(GP_SEL_W), .FX_SEL_W(FX_SEL_W)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_index(rd_index),
        .gp_rsel(gp_rsel), .gp_rval(gp_rval),
        .fx_rsel(fx_rsel), .fx_rval(fx_rval),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_fault(rd_fault)
    );

endmodule

// File: tb/tb_ctr_access_front.sv
`timescale 1ns/1ps
// Bench: external counter arrays plus a behavioural reference model,
// compared against every output on every clock.
module tb_ctr_access_front;

    localparam int NUM_GP = 4;
    localparam int NUM_FX = 3;
    localparam int GP_W   = 48;
    localparam int FX_W   = 40;
    localparam int NUM_W  = 4;
    localparam logic [63:0] GMASK = (64'd1 << GP_W) - 64'd1;
    localparam logic [63:0] FMASK = (64'd1 << FX_W) - 64'd1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_kind = 2'd3;
    logic [NUM_W-1:0] wr_num = '0;
    logic [63:0] wr_data = '0;
    logic rd_en = 1'b0;
    logic [31:0] rd_index = '0;
    logic gp_we, fx_we, wr_fault, rd_valid, rd_fault;
    logic [1:0] gp_wsel, fx_wsel, gp_rsel, fx_rsel;
    logic [GP_W-1:0] gp_wval, gp_rval;
    logic [FX_W-1:0] fx_wval, fx_rval;
    logic [63:0] rd_data;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ctr_access_front #(.NUM_GP(NUM_GP), .NUM_FX(NUM_FX), .GP_W(GP_W),
                       .FX_W(FX_W), .NUM_W(NUM_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_num(wr_num), .wr_data(wr_data), .rd_en(rd_en), .rd_index(rd_index),
        .gp_we(gp_we), .gp_wsel(gp_wsel), .gp_wval(gp_wval),
        .fx_we(fx_we), .fx_wsel(fx_wsel), .fx_wval(fx_wval),
        .gp_rsel(gp_rsel), .gp_rval(gp_rval), .fx_rsel(fx_rsel), .fx_rval(fx_rval),
        .wr_fault(wr_fault), .rd_valid(rd_valid), .rd_data(rd_data), .rd_fault(rd_fault)
    );

    // External counter arrays driven by the design's strobes.
    logic [GP_W-1:0] gp_mem [NUM_GP];
    logic [FX_W-1:0] fx_mem [4];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_GP; i++) gp_mem[i] <= '0;
            for (int i = 0; i < 4; i++) fx_mem[i] <= '0;
        end else begin
            if (gp_we) gp_mem[gp_wsel] <= gp_wval;
            if (fx_we) fx_mem[fx_wsel] <= fx_wval;
        end
    end
    assign gp_rval = gp_mem[gp_rsel];
    assign fx_rval = fx_mem[fx_rsel];

    // Reference state.
    logic [63:0] ref_gp [NUM_GP];
    logic [63:0] ref_fx [NUM_FX];

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock of stimulus; predicts outputs from the requirements and compares.
    task automatic cyc(input string tag, input logic we, input logic [1:0] kind,
                       input int num, input logic [63:0] d,
                       input logic re, input logic [31:0] idx);
        logic [63:0] e_data;
        logic e_rf, e_wf;
        int rn;
        wr_en = we; wr_kind = kind; wr_num = NUM_W'(num); wr_data = d;
        rd_en = re; rd_index = idx;
        e_data = '0; e_rf = 1'b0; e_wf = 1'b0;
        rn = int'(idx[29:0]);
        if (re) begin
            if (idx[30] ? (rn >= NUM_FX) : (rn >= NUM_GP)) e_rf = 1'b1;
            else begin
                e_data = idx[30] ? ref_fx[rn] : ref_gp[rn];
                if (idx[31]) e_data = e_data & 64'h0000_0000_FFFF_FFFF;
            end
        end
        if (we) begin
            case (kind)
                2'd0: if (num < NUM_GP) ref_gp[num] = {{32{d[31]}}, d[31:0]} & GMASK;
                      else e_wf = 1'b1;
                2'd1: if (num < NUM_GP && (d & ~GMASK) == 0) ref_gp[num] = d;
                      else e_wf = 1'b1;
                2'd2: if (num < NUM_FX) ref_fx[num] = d & FMASK;
                      else e_wf = 1'b1;
                default: ;
            endcase
        end
        @(negedge clk);
        chk(tag, "rd_valid", 64'(rd_valid), 64'(re));
        chk(tag, "rd_data", rd_data, e_data);
        chk(tag, "rd_fault", 64'(rd_fault), 64'(e_rf));
        chk(tag, "wr_fault", 64'(wr_fault), 64'(e_wf));
    endtask

    task automatic rd(input string tag, input logic [31:0] idx);
        cyc(tag, 1'b0, 2'd3, 0, 64'd0, 1'b1, idx);
    endtask

    task automatic wr(input string tag, input logic [1:0] kind, input int num,
                      input logic [63:0] d);
        cyc(tag, 1'b1, kind, num, d, 1'b0, 32'd0);
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        for (int i = 0; i < NUM_GP; i++) ref_gp[i] = '0;
        for (int i = 0; i < NUM_FX; i++) ref_fx[i] = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state of every output.
        chk("R9", "reset rd_valid", 64'(rd_valid), 64'd0);
        chk("R9", "reset rd_data", rd_data, 64'd0);
        chk("R9", "reset faults", 64'({rd_fault, wr_fault}), 64'd0);
        rst_n = 1'b1;
        cyc("R9", 1'b0, 2'd0, 0, 64'd0, 1'b0, 32'd0);

        // R1: legacy alias sign-extension, negative and positive with junk upper word.
        wr("R1", 2'd0, 0, 64'h0000_0000_89AB_CDEF);
        rd("R1", 32'h0000_0000);
        chk("R1", "sign-extended literal", ref_gp[0], 64'h0000_FFFF_89AB_CDEF);
        wr("R1", 2'd0, 1, 64'hFFFF_FFFF_1234_5678);
        rd("R1", 32'h0000_0001);

        // R2: full-width alias, normal and top-of-range values.
        wr("R2", 2'd1, 2, 64'h0000_8123_4567_89AB);
        rd("R2", 32'h0000_0002);
        // R3: oversize data, far and at the boundary bit, leave the counter alone.
        wr("R3", 2'd1, 2, 64'h00FF_0123_4567_89AB);
        rd("R3", 32'h0000_0002);
        wr("R3", 2'd1, 2, 64'h0001_0000_0000_0000);
        rd("R3", 32'h0000_0002);
        wr("R2", 2'd1, 2, 64'h0000_FFFF_FFFF_FFFF);
        rd("R2", 32'h0000_0002);

        // R6: both aliases reach the same storage; classes are distinct.
        wr("R6", 2'd1, 3, 64'h0000_7FFF_0000_0001);
        rd("R6", 32'h0000_0003);
        wr("R6", 2'd0, 3, 64'h0000_0000_7FFF_0001);
        rd("R6", 32'h0000_0003);

        // R4: fixed class truncation.
        wr("R4", 2'd2, 1, 64'hFFFF_FF01_2345_6789);
        rd("R4", 32'h4000_0001);
        wr("R4", 2'd2, 0, 64'h1234_5678_9ABC_DEF0);
        rd("R6", 32'h4000_0000);
        rd("R6", 32'h0000_0000);

        // R7: fast mode on both classes.
        rd("R7", 32'hC000_0001);
        rd("R7", 32'h8000_0002);
        rd("R7", 32'h8000_0000);

        // R5: writes to absent counters.
        wr("R5", 2'd0, 4, 64'h0000_0000_0000_0055);
        wr("R5", 2'd1, 15, 64'h0000_0000_0000_0066);
        wr("R5", 2'd2, 3, 64'h0000_0000_0000_0077);
        rd("R5", 32'h0000_0000);
        rd("R5", 32'h4000_0002);

        // R8: reads beyond the count, including high number bits.
        rd("R8", 32'h0000_0004);
        rd("R8", 32'h4000_0003);
        rd("R8", 32'h0000_1000);
        rd("R8", 32'hC000_0005);

        // R10: no-op kind and disabled write leave storage untouched.
        wr("R10", 2'd3, 0, 64'h0000_0000_DEAD_BEEF);
        cyc("R10", 1'b0, 2'd0, 1, 64'h0000_0000_0000_0BAD, 1'b0, 32'd0);
        rd("R10", 32'h0000_0000);
        rd("R10", 32'h0000_0001);

        // R9: same-cycle read and write return the old value, then the new one.
        cyc("R9", 1'b1, 2'd0, 0, 64'h0000_0000_0000_0001, 1'b1, 32'h0000_0000);
        rd("R9", 32'h0000_0000);
        cyc("R9", 1'b0, 2'd0, 0, 64'd0, 1'b0, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule